// File: doc/BRIEF.md
# Tiled Fence Descriptor Write Sequencer

This block programs or clears one numbered tiling fence slot. A fence slot is a 64-bit descriptor held as two 32-bit registers, a low word and a high word. Because the two halves cannot be written at once, the block orders its word writes so that the fence is never valid while only half of it has been updated. A program request carries a surface start address, a byte size, a row stride and a tiling mode. The block trims the size down to whole tile rows, builds the descriptor and sends it out as a series of 32-bit writes. It waits for each write to be acknowledged before sending the next one.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle. A request transfers on a rising edge where `req_valid` and `req_ready` are both high, and the request fields are captured at that edge. A held `req_valid` is simply stalled while a sequence runs. The write port is a valid/ready channel as well. A write completes on an edge where `wr_valid` and `wr_ready` are both high. Until that edge, `wr_valid`, `wr_addr` and `wr_data` hold steady, and `wr_ready` is the acknowledgement that the write has landed. `busy`, `done` and `err` are plain status outputs.

The size trim is done by an iterative divider. The divider runs while the first write, the disabling write, is still waiting for its acknowledgement. The high word is held back until both the divider has finished and the disabling write has been acknowledged.

Top module: `fence_seq`

## Requirements
- R1: A request transfers on an edge with `req_valid` and `req_ready` both high. `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after a good request transfers and falls in the cycle after the final write of its sequence is acknowledged.
- R2: The first write of every good request puts 0 into the low word of the slot. The low word of slot n is at address BASE_ADDR + 8·n, and BASE_ADDR is a multiple of 8.
- R3: Once `wr_valid` is raised, `wr_valid`, `wr_addr` and `wr_data` hold until the edge where `wr_ready` is high. No later write of the sequence appears before that edge.
- R4: A program request (`req_clear`=0) makes exactly three writes, in this order: low word 0, then the high word descriptor at BASE_ADDR + 8·n + 4, then the low word descriptor, which carries the valid bit.
- R5: A clear request (`req_clear`=1) makes exactly two writes: 0 to the low word, then 0 to the high word. The stride and tiling fields of a clear request have no effect.
- R6: Tiling code 1 means X and code 2 means Y. The fenced size is the request size rounded down to a whole number of rows. A row is stride·8 bytes for X and stride·32 bytes for Y.
- R7: Bits [31:12] of the high word are bits [31:12] of (start + trimmed size − 4096), computed modulo 2^32. Bits [11:0] of the high word are 0 when `cfg_pitch_alt`=0.
- R8: The low word holds start[31:12] in bits [31:12], the Y flag in bit 1 (set only for code 2) and the valid bit in bit 0, which is set. The pitch value is stride/128 − 1 (integer division), taken to 10 bits. With `cfg_pitch_alt`=0 the pitch sits in low word bits [11:2]. With `cfg_pitch_alt`=1 it sits in high word bits [9:0] (descriptor bits [41:32]), and low word bits [11:2] are 0.
- R9: A request is rejected if it is a program with stride 0, a program with tiling code 0 or 3, or any request with slot ≥ NUM_SLOTS. A rejected request pulses `err` for one cycle in the cycle after it transfers, makes no write and gives no `done`.
- R10: `done` pulses for one cycle, in the cycle after the final write of a sequence is acknowledged.
- R11: The disabling write may complete before or after the size trim finishes, including in the same cycle. In every case the high word carries the trimmed value of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_clear | input | 1 | 1 = clear the slot, 0 = program the slot |
| req_slot | input | SLOT_W | Fence slot number |
| req_start | input | 32 | Surface start address |
| req_size | input | 32 | Surface size in bytes |
| req_stride | input | STRIDE_W | Row stride in bytes |
| req_tiling | input | 2 | 0 none, 1 X, 2 Y, 3 reserved |
| cfg_pitch_alt | input | 1 | Pitch layout select, captured with the request |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Write acknowledged |
| wr_addr | output | 32 | Register byte address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two activities can land in the same cycle: the acknowledgement of the disabling write and the last step of the size-trim divider. When both happen together, the sequencer must go straight to the high-word write. It must neither lose the result nor skip the wait. The bench brings this about by sweeping the write-acknowledge latency over a range that places the first acknowledgement before, on and after the divider's final cycle. For each latency it judges the captured write stream against a descriptor computed arithmetically. Held request offers during a running sequence check that `req_ready` stays low the whole time.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_BITS  = 12;
  localparam int VALID_BIT  = 0;
  localparam int YFLAG_BIT  = 1;

  typedef enum logic [1:0] {
    TILE_NONE = 2'd0,
    TILE_X    = 2'd1,
    TILE_Y    = 2'd2,
    TILE_RSVD = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIS,
    ST_WAIT,
    ST_HI,
    ST_LO,
    ST_CLRHI
  } seq_e;
endpackage

// File: rtl/fence_rowdiv.sv
// Iterative restoring divider: yields size mod row, one dividend bit per cycle.
module fence_rowdiv #(
  parameter int SIZE_W = 32,
  parameter int ROW_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] dividend,
  input  logic [ROW_W-1:0]  divisor,
  output logic              rdy,
  output logic [ROW_W-1:0]  rem
);
  localparam int CNT_W = $clog2(SIZE_W + 1);

  logic [ROW_W-1:0]  rem_q;
  logic [SIZE_W-1:0] dvd_q;
  logic [ROW_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;

  logic [ROW_W:0]    trial;
  logic [ROW_W:0]    diff;
  logic              fits;
  logic [ROW_W-1:0]  rem_n;
  logic              unused_diff_top;

  always_comb begin
    trial = {rem_q, dvd_q[SIZE_W-1]};
    diff  = trial - {1'b0, div_q};
    fits  = trial >= {1'b0, div_q};
    rem_n = fits ? diff[ROW_W-1:0] : trial[ROW_W-1:0];
  end
  assign unused_diff_top = diff[ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvd_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      dvd_q <= dividend;
      div_q <= divisor;
      cnt_q <= CNT_W'(SIZE_W);
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= rem_n;
      dvd_q <= dvd_q << 1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign rdy = !run_q;
  assign rem = rem_q;
endmodule

// File: rtl/fence_desc.sv
// Builds both descriptor words from the captured request and the row remainder.
module fence_desc
  import fence_pkg::*;
#(
  parameter int STRIDE_W     = 16,
  parameter int ROW_W        = 21,
  parameter int PITCH_W      = 10,
  parameter int PITCH_LO_POS = 2
) (
  input  logic [WORD_W-1:0]   start_i,
  input  logic [WORD_W-1:0]   size_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                is_y_i,
  input  logic                alt_i,
  input  logic [ROW_W-1:0]    rem_i,
  output logic [WORD_W-1:0]   hi_o,
  output logic [WORD_W-1:0]   lo_o
);
  localparam logic [WORD_W-1:0] PAGE_MASK = ~((WORD_W'(1) << PAGE_BITS) - 1'b1);
  localparam logic [WORD_W-1:0] PAGE_SZ   = WORD_W'(1) << PAGE_BITS;

  logic [WORD_W-1:0]  trimmed;
  logic [WORD_W-1:0]  last_pg;
  logic [PITCH_W-1:0] pitch;

  always_comb begin
    trimmed = size_i - WORD_W'(rem_i);
    last_pg = (start_i + trimmed - PAGE_SZ) & PAGE_MASK;
    pitch   = PITCH_W'(stride_i >> 7) - PITCH_W'(1);
    hi_o    = last_pg;
    lo_o    = (start_i & PAGE_MASK);
    lo_o[VALID_BIT] = 1'b1;
    lo_o[YFLAG_BIT] = is_y_i;
    if (alt_i) hi_o = hi_o | WORD_W'(pitch);
    else       lo_o = lo_o | (WORD_W'(pitch) << PITCH_LO_POS);
  end
endmodule

// File: rtl/fence_wrseq.sv
// Orders the word writes and waits for each acknowledge.
module fence_wrseq
  import fence_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_clr,
  input  logic              div_rdy,
  input  logic [WORD_W-1:0] lo_addr,
  input  logic [WORD_W-1:0] hi_addr,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  seq_e state_q, state_n;
  logic clr_q;
  logic fin;

  always_comb begin
    state_n  = state_q;
    wr_valid = 1'b0;
    wr_addr  = lo_addr;
    wr_data  = '0;
    fin      = 1'b0;
    case (state_q)
      ST_IDLE: if (go_prog || go_clr) state_n = ST_DIS;
      ST_DIS: begin
        wr_valid = 1'b1;
        if (wr_ready) begin
          if (clr_q)        state_n = ST_CLRHI;
          else if (div_rdy) state_n = ST_HI;
          else              state_n = ST_WAIT;
        end
      end
      ST_WAIT: if (div_rdy) state_n = ST_HI;
      ST_HI: begin
        wr_valid = 1'b1;
        wr_addr  = hi_addr;
        wr_data  = hi_word;
        if (wr_ready) state_n = ST_LO;
      end
      ST_LO: begin
        wr_valid = 1'b1;
        wr_data  = lo_word;
        if (wr_ready) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
        end
      end
      ST_CLRHI: begin
        wr_valid = 1'b1;
        wr_addr  = hi_addr;
        if (wr_ready) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clr_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      done    <= fin;
      if (state_q == ST_IDLE && (go_prog || go_clr)) clr_q <= go_clr;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/fence_seq.sv
// Top: request intake, validation, slot addressing and sub-block wiring.
module fence_seq
  import fence_pkg::*;
#(
  parameter int               NUM_SLOTS    = 16,
  parameter logic [31:0]      BASE_ADDR    = 32'h0010_0000,
  parameter int               STRIDE_W     = 16,
  parameter int               PITCH_W      = 10,
  parameter int               PITCH_LO_POS = 2,
  parameter int               SLOT_W       = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_clear,
  input  logic [SLOT_W-1:0]   req_slot,
  input  logic [31:0]         req_start,
  input  logic [31:0]         req_size,
  input  logic [STRIDE_W-1:0] req_stride,
  input  logic [1:0]          req_tiling,
  input  logic                cfg_pitch_alt,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [31:0]         wr_addr,
  output logic [31:0]         wr_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  localparam int ROW_W = STRIDE_W + 5;

  logic                accept, bad, go_prog, go_clr;
  logic                tile_ok;
  logic [ROW_W-1:0]    row_bytes;
  logic [SLOT_W-1:0]   slot_q;
  logic [WORD_W-1:0]   start_q, size_q;
  logic [STRIDE_W-1:0] stride_q;
  logic                y_q, alt_q;
  logic                div_rdy;
  logic [ROW_W-1:0]    rem;
  logic [WORD_W-1:0]   hi_word, lo_word, lo_addr, hi_addr;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign tile_ok   = (req_tiling == TILE_X) || (req_tiling == TILE_Y);
  assign bad       = ({1'b0, req_slot} >= (SLOT_W+1)'(NUM_SLOTS)) ||
                     (!req_clear && (req_stride == '0 || !tile_ok));
  assign go_prog   = accept && !bad && !req_clear;
  assign go_clr    = accept && !bad && req_clear;

  assign row_bytes = (req_tiling == TILE_Y) ? {req_stride, 5'b0}
                                            : {2'b0, req_stride, 3'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      start_q  <= '0;
      size_q   <= '0;
      stride_q <= '0;
      y_q      <= 1'b0;
      alt_q    <= 1'b0;
      err      <= 1'b0;
    end else begin
      err <= accept && bad;
      if (go_prog || go_clr) begin
        slot_q   <= req_slot;
        start_q  <= req_start;
        size_q   <= req_size;
        stride_q <= req_stride;
        y_q      <= (req_tiling == TILE_Y);
        alt_q    <= cfg_pitch_alt;
      end
    end
  end

  assign lo_addr = BASE_ADDR + (WORD_W'(slot_q) << 3);
  assign hi_addr = lo_addr + 32'd4;

  fence_rowdiv #(.SIZE_W(WORD_W), .ROW_W(ROW_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go_prog),
    .dividend (req_size),
    .divisor  (row_bytes),
    .rdy      (div_rdy),
    .rem      (rem)
  );

  fence_desc #(
    .STRIDE_W(STRIDE_W), .ROW_W(ROW_W),
    .PITCH_W(PITCH_W), .PITCH_LO_POS(PITCH_LO_POS)
  ) u_desc (
    .start_i  (start_q),
    .size_i   (size_q),
    .stride_i (stride_q),
    .is_y_i   (y_q),
    .alt_i    (alt_q),
    .rem_i    (rem),
    .hi_o     (hi_word),
    .lo_o     (lo_word)
  );

  fence_wrseq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_prog  (go_prog),
    .go_clr   (go_clr),
    .div_rdy  (div_rdy),
    .lo_addr  (lo_addr),
    .hi_addr  (hi_addr),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/fence_seq_chk.sv
module fence_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done,
  input logic        err
);
  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  a_r2_disable_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!wr_valid || (wr_data == 32'd0 && !wr_addr[2])));

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r4_valid_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_addr[2] && wr_data[0]) |=> done);

  a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_valid && !busy && !done));

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind fence_seq fence_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/fence_seq_tb.sv
`timescale 1ns/1ps
module fence_seq_tb;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_clear = 1'b0;
  logic [3:0]  req_slot = '0;
  logic [31:0] req_start = '0;
  logic [31:0] req_size = '0;
  logic [15:0] req_stride = '0;
  logic [1:0]  req_tiling = '0;
  logic        cfg_pitch_alt = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        busy, done, err;

  fence_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_clear(req_clear), .req_slot(req_slot), .req_start(req_start),
    .req_size(req_size), .req_stride(req_stride), .req_tiling(req_tiling),
    .cfg_pitch_alt(cfg_pitch_alt), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int ack_cnt = 0;
  int log_n = 0;
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  int cycles = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write acknowledge responder with programmable latency; logs each transfer
  always @(negedge clk) begin
    if (wr_ready) begin
      wr_ready = 1'b0;
      ack_cnt  = 0;
    end else if (wr_valid) begin
      if (ack_cnt >= lat) begin
        wr_ready = 1'b1;
        if (log_n < 8) begin
          log_addr[log_n] = wr_addr;
          log_data[log_n] = wr_data;
        end
        log_n++;
      end else begin
        ack_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] f_hi(input logic [31:0] st, input logic [31:0] sz,
                                       input int strd, input bit y, input bit alt);
    longint unsigned row, trim;
    logic [31:0] last, p;
    row  = longint'(strd) * (y ? 32 : 8);
    trim = (longint'(sz) / row) * row;
    last = (st + 32'(trim) - 32'd4096) & 32'hFFFF_F000;
    p    = 32'((strd / 128 - 1) & 10'h3FF);
    return alt ? (last | p) : last;
  endfunction

  function automatic logic [31:0] f_lo(input logic [31:0] st, input int strd,
                                       input bit y, input bit alt);
    logic [31:0] v, p;
    p = 32'((strd / 128 - 1) & 10'h3FF);
    v = (st & 32'hFFFF_F000) | {30'd0, y, 1'b1};
    return alt ? v : (v | (p << 2));
  endfunction

  task automatic run_op(input bit clr, input int slot, input logic [31:0] st,
                        input logic [31:0] sz, input int strd, input logic [1:0] tl,
                        input bit alt, input int l, input bit exp_err, input string tag);
    bit saw_done, bp_bad, y;
    int t;
    logic [31:0] ea [3];
    logic [31:0] ed [3];
    int en;
    @(negedge clk);
    lat = l; log_n = 0;
    req_clear = clr; req_slot = 4'(slot); req_start = st; req_size = sz;
    req_stride = 16'(strd); req_tiling = tl; cfg_pitch_alt = alt;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) begin
      check(err == 1'b1, "R9 err pulse", 32'(err), 32'd1);
      saw_done = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done || busy) saw_done = 1'b1;
      end
      check(log_n == 0, "R9 no writes", 32'(log_n), 32'd0);
      check(!saw_done, "R9 no done/busy", 32'(saw_done), 32'd0);
    end else begin
      check(err == 1'b0 && busy == 1'b1, {"R1 busy after accept ", tag},
            {30'd0, err, busy}, 32'd1);
      t = 0; bp_bad = 1'b0;
      while (!done && t < 3000) begin
        if (busy && req_ready) bp_bad = 1'b1;
        @(negedge clk);
        t++;
      end
      check(done == 1'b1, {"R10 done pulse ", tag}, 32'(done), 32'd1);
      check(!busy && !bp_bad, {"R1 ready/busy ", tag}, {30'd0, busy, bp_bad}, 32'd0);
      y = (tl == 2'd2);
      ea[0] = BASE + 32'(slot) * 8; ed[0] = 32'd0;
      ea[1] = ea[0] + 32'd4;
      if (clr) begin
        en = 2; ed[1] = 32'd0; ea[2] = '0; ed[2] = '0;
      end else begin
        en = 3;
        ed[1] = f_hi(st, sz, strd, y, alt);
        ea[2] = ea[0];
        ed[2] = f_lo(st, strd, y, alt);
      end
      check(log_n == en, clr ? "R5 write count" : "R4 write count", 32'(log_n), 32'(en));
      for (int k = 0; k < en && k < log_n; k++) begin
        check(log_addr[k] == ea[k], {(k == 0) ? "R2 addr " : "R4 addr ", tag},
              log_addr[k], ea[k]);
        if (k == 0)
          check(log_data[k] == ed[k], {"R2 disable data ", tag}, log_data[k], ed[k]);
        else if (clr)
          check(log_data[k] == ed[k], {"R5 clear data ", tag}, log_data[k], ed[k]);
        else if (k == 1)
          check(log_data[k] == ed[k], {"R6 R7 high word ", tag}, log_data[k], ed[k]);
        else
          check(log_data[k] == ed[k], {"R8 low word ", tag}, log_data[k], ed[k]);
      end
    end
  endtask

  initial begin
    int strides [5];
    logic [31:0] sizes [3];
    int opn;
    strides = '{128, 256, 384, 640, 1024};
    sizes   = '{32'h0004_0000, 32'h0012_3456, 32'h0009_A777};
    repeat (3) @(negedge clk);
    check(busy == 0 && wr_valid == 0 && done == 0 && err == 0,
          "R1 reset outputs", {28'd0, busy, wr_valid, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);

    // R5: clear every slot, stride/tiling fields set to junk
    for (int s = 0; s < 16; s++)
      run_op(1'b1, s, 32'hDEAD_BEEF, 32'h1234, 0, 2'd3, 1'b0, s % 4, 1'b0, "R5 clear");

    // R6 R7 R8: sweep tiling, stride, size, pitch layout and slot
    opn = 0;
    for (int tl = 1; tl <= 2; tl++)
      for (int si = 0; si < 5; si++)
        for (int zi = 0; zi < 3; zi++)
          for (int alt = 0; alt < 2; alt++) begin
            run_op(1'b0, opn % 16, 32'h0100_0234 + 32'(opn) * 32'h0011_1000, sizes[zi],
                   strides[si], 2'(tl), alt[0], opn % 5, 1'b0, "R6 sweep");
            opn++;
          end

    // R11: acknowledge latency sweep around the end of the size trim
    for (int l = 0; l <= 40; l++)
      run_op(1'b0, l % 16, 32'h2000_0FFF, 32'h0005_5555, 512, 2'd2, l[0], l,
             1'b0, "R11 overlap");

    // R8: stride not a multiple of 128, smallest pitch
    run_op(1'b0, 3, 32'h0300_0000, 32'h0001_0000, 200, 2'd1, 1'b0, 1, 1'b0, "R8 odd stride");
    run_op(1'b0, 4, 32'h0300_0000, 32'h0001_0000, 200, 2'd2, 1'b1, 2, 1'b0, "R8 odd stride alt");

    // R9: rejected requests
    run_op(1'b0, 1, 32'h1000_0000, 32'h1_0000, 0,   2'd1, 1'b0, 0, 1'b1, "R9");
    run_op(1'b0, 2, 32'h1000_0000, 32'h1_0000, 256, 2'd0, 1'b0, 0, 1'b1, "R9");
    run_op(1'b0, 3, 32'h1000_0000, 32'h1_0000, 256, 2'd3, 1'b1, 0, 1'b1, "R9");

    // after rejects, a program still works
    run_op(1'b0, 15, 32'h7FFF_F000, 32'h0002_0000, 128, 2'd1, 1'b0, 3, 1'b0, "R4 after err");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule